// File: doc/BRIEF.md
# Single-Precision Minimum/Maximum Selector

This block picks one of two IEEE single-precision operands according to a 3-bit operation code. It serves the six min/max flavours an FPU needs: plain min and max, number-preferring min and max (a quiet NaN gives way to a number), and the magnitude-based variants of the number-preferring pair. Each operand is classified as zero, normal, subnormal, infinity, quiet NaN or signalling NaN. Ordering is decided on magnitude first and then on sign, following the mode rules below.

A request is accepted on any cycle with `in_valid_i` high. The chosen value and an invalid-operation flag leave one register stage later together with `out_valid_o`. No rounding takes place: the output is always either one of the inputs, bit for bit, or the canonical quiet NaN.

Top module: `fmm_unit`

## Requirements
- R1: `op_i` is a bitmask. Bit 0 high selects minimum and low selects maximum. Bit 1 selects number-preferring NaN handling. Bit 2 selects magnitude ordering. The codes are max=000, min=001, maxNum=010, minNum=011, maxNumMag=110, minNumMag=111.
- R2: `out_valid_o` is high exactly one clock after a cycle with `in_valid_i` high, and `result_o`/`invalid_o` belong to that request. Reset (`rst_ni` low) clears `out_valid_o`.
- R3: When `op_i[1]` is 1, one operand is a quiet NaN (exponent all ones, fraction bit 22 set), the other is not a NaN, and neither is a signalling NaN, the non-NaN operand is returned unchanged with `invalid_o` low.
- R4: Every other input pair that contains a NaN returns 0x7FC00000. This covers any signalling NaN, two NaNs, and any NaN when `op_i[1]` is 0.
- R5: `invalid_o` is high exactly when at least one input is a signalling NaN (exponent all ones, fraction bit 22 clear, fraction nonzero).
- R6: Magnitudes order infinity above every finite value and zero below every nonzero value. Finite magnitudes compare by exponent, then by fraction. Subnormals take part through their raw bits, with no flush to zero.
- R7: Outside magnitude mode, a negative operand is less than a positive one, and two negatives order in reverse of their magnitudes. -0 (0x80000000) is therefore less than +0.
- R8: In magnitude mode the larger magnitude is the greater value whatever its sign. Signs decide only when the magnitudes are equal.
- R9: When the two operands compare as exactly equal, operand A is returned.
- R10: Code 100 orders by magnitude and handles NaNs as plain max does, so any NaN yields 0x7FC00000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request strobe |
| op_i | input | 3 | Operation code: bit0 min, bit1 number-preferring, bit2 magnitude |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| out_valid_o | output | 1 | Result strobe, one cycle after the request |
| result_o | output | 32 | Selected operand or canonical quiet NaN |
| invalid_o | output | 1 | Invalid-operation flag |

## Verification
The properties assume that `op_i`, `a_i` and `b_i` are meaningful only in cycles where `in_valid_i` is high. They also assume that no reset lands between a request and its result. The stimulus holds the operands steady with the strobe and applies reset only at the start. Every 3-bit code, including 100, is a legal mode, so the bench drives all of them. The operand patterns cover both zero signs, subnormals, infinities and both NaN kinds.

// File: rtl/fmm_pkg.sv
package fmm_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO, CLS_NORM, CLS_SUB, CLS_INF, CLS_QNAN, CLS_SNAN
  } fp_cls_e;

  localparam int unsigned OP_W       = 3;
  localparam int unsigned OP_MIN_BIT = 0;
  localparam int unsigned OP_NUM_BIT = 1;
  localparam int unsigned OP_MAG_BIT = 2;
endpackage

// File: rtl/fmm_classify.sv
module fmm_classify
  import fmm_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] val_i,
  output fp_cls_e      cls_o
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_zero, exp_ones, frac_zero;

  assign exp_f     = val_i[W-2 -: EXP_W];
  assign frac_f    = val_i[FRAC_W-1:0];
  assign exp_zero  = (exp_f == '0);
  assign exp_ones  = (exp_f == '1);
  assign frac_zero = (frac_f == '0);

  always_comb begin
    if (exp_zero)       cls_o = frac_zero ? CLS_ZERO : CLS_SUB;
    else if (!exp_ones) cls_o = CLS_NORM;
    else if (frac_zero) cls_o = CLS_INF;
    else                cls_o = frac_f[FRAC_W-1] ? CLS_QNAN : CLS_SNAN;
  end
endmodule

// File: rtl/fmm_order.sv
module fmm_order
  import fmm_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned W     = 1 + EXP_W + FRAC_W,
  localparam int unsigned KEY_W = 2 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  fp_cls_e      cls_a_i,
  input  fp_cls_e      cls_b_i,
  input  logic         mag_mode_i,
  input  logic         min_mode_i,
  output logic         pick_b_o
);
  logic [KEY_W-1:0] key_a, key_b;
  logic mag_gt, mag_eq, sa, sb, a_gt, a_eq, a_lt;

  // rank: infinity on top, zero at bottom, else exponent then fraction
  assign key_a = {cls_a_i == CLS_INF, cls_a_i != CLS_ZERO,
                  (cls_a_i == CLS_ZERO) ? {(W-1){1'b0}} : a_i[W-2:0]};
  assign key_b = {cls_b_i == CLS_INF, cls_b_i != CLS_ZERO,
                  (cls_b_i == CLS_ZERO) ? {(W-1){1'b0}} : b_i[W-2:0]};

  assign mag_gt = key_a > key_b;
  assign mag_eq = key_a == key_b;
  assign sa     = a_i[W-1];
  assign sb     = b_i[W-1];

  always_comb begin
    if (mag_mode_i && !mag_eq) begin
      a_gt = mag_gt;
      a_eq = 1'b0;
    end else if (sa != sb) begin
      a_gt = sb;
      a_eq = 1'b0;
    end else if (sa) begin
      a_gt = !mag_gt && !mag_eq;
      a_eq = mag_eq;
    end else begin
      a_gt = mag_gt;
      a_eq = mag_eq;
    end
  end

  assign a_lt     = !a_gt && !a_eq;
  assign pick_b_o = min_mode_i ? a_gt : a_lt;
endmodule

// File: rtl/fmm_nan_sel.sv
module fmm_nan_sel
  import fmm_pkg::*;
(
  input  fp_cls_e cls_a_i,
  input  fp_cls_e cls_b_i,
  input  logic    num_mode_i,
  output logic    nan_path_o,
  output logic    pass_num_o,
  output logic    pass_b_o,
  output logic    invalid_o
);
  logic nan_a, nan_b, snan_any;

  assign nan_a    = (cls_a_i == CLS_QNAN) || (cls_a_i == CLS_SNAN);
  assign nan_b    = (cls_b_i == CLS_QNAN) || (cls_b_i == CLS_SNAN);
  assign snan_any = (cls_a_i == CLS_SNAN) || (cls_b_i == CLS_SNAN);

  assign pass_num_o = num_mode_i && !snan_any && (nan_a ^ nan_b);
  assign pass_b_o   = nan_a;
  assign nan_path_o = (nan_a || nan_b) && !pass_num_o;
  assign invalid_o  = snan_any;
endmodule

// File: rtl/fmm_unit.sv
module fmm_unit
  import fmm_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned W     = 1 + EXP_W + FRAC_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  output logic            out_valid_o,
  output logic [W-1:0]    result_o,
  output logic            invalid_o
);
  localparam logic [W-1:0] QNAN_C = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic [W-1:0] opnd [2];
  fp_cls_e      cls  [2];
  logic         nan_path, pass_num, pass_b, inval_c, ord_pick_b;
  logic [W-1:0] res_c;

  assign opnd[0] = a_i;
  assign opnd[1] = b_i;

  for (genvar i = 0; i < 2; i++) begin : g_cls
    fmm_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .val_i (opnd[i]),
      .cls_o (cls[i])
    );
  end

  fmm_nan_sel u_nan (
    .cls_a_i    (cls[0]),
    .cls_b_i    (cls[1]),
    .num_mode_i (op_i[OP_NUM_BIT]),
    .nan_path_o (nan_path),
    .pass_num_o (pass_num),
    .pass_b_o   (pass_b),
    .invalid_o  (inval_c)
  );

  fmm_order #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_ord (
    .a_i        (a_i),
    .b_i        (b_i),
    .cls_a_i    (cls[0]),
    .cls_b_i    (cls[1]),
    .mag_mode_i (op_i[OP_MAG_BIT]),
    .min_mode_i (op_i[OP_MIN_BIT]),
    .pick_b_o   (ord_pick_b)
  );

  always_comb begin
    if (nan_path)      res_c = QNAN_C;
    else if (pass_num) res_c = pass_b ? b_i : a_i;
    else               res_c = ord_pick_b ? b_i : a_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_valid_o <= 1'b0;
    else         out_valid_o <= in_valid_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o  <= '0;
      invalid_o <= 1'b0;
    end else if (in_valid_i) begin
      result_o  <= res_c;
      invalid_o <= inval_c;
    end
  end
endmodule

// File: rtl/fmm_unit_chk.sv
module fmm_unit_chk #(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned W     = 1 + EXP_W + FRAC_W
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         in_valid_i,
  input logic [2:0]   op_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         out_valid_o,
  input logic [W-1:0] result_o,
  input logic         invalid_o
);
  localparam logic [W-1:0] QNAN_C = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic a_nan, b_nan, a_sn, b_sn, a_qn;
  assign a_nan = (a_i[W-2 -: EXP_W] == '1) && (a_i[FRAC_W-1:0] != '0);
  assign b_nan = (b_i[W-2 -: EXP_W] == '1) && (b_i[FRAC_W-1:0] != '0);
  assign a_sn  = a_nan && !a_i[FRAC_W-1];
  assign b_sn  = b_nan && !b_i[FRAC_W-1];
  assign a_qn  = a_nan && a_i[FRAC_W-1];

  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  a_r2_no_spurious_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);
  a_r5_snan_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && (a_sn || b_sn) |=> invalid_o && result_o == QNAN_C);
  a_r5_clean_no_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && !a_sn && !b_sn |=> !invalid_o);
  a_r3_num_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && op_i[1] && a_qn && !b_nan |=> result_o == $past(b_i));
  a_r4_plain_nan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && !op_i[1] && (a_nan || b_nan) |=> result_o == QNAN_C);
  a_r9_tie_keeps_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && !a_nan && a_i == b_i |=> result_o == $past(a_i));
endmodule

bind fmm_unit fmm_unit_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .op_i        (op_i),
  .a_i         (a_i),
  .b_i         (b_i),
  .out_valid_o (out_valid_o),
  .result_o    (result_o),
  .invalid_o   (invalid_o)
);

// File: tb/sim_fmm_unit.sv
module sim_fmm_unit;
  localparam int CLK_PERIOD = 10;

  localparam logic [31:0] PZ = 32'h0000_0000, NZ = 32'h8000_0000;
  localparam logic [31:0] P1 = 32'h3F80_0000, N1 = 32'hBF80_0000;
  localparam logic [31:0] P2 = 32'h4000_0000, N2 = 32'hC000_0000;
  localparam logic [31:0] P15 = 32'h3FC0_0000;
  localparam logic [31:0] PI = 32'h7F80_0000, NI = 32'hFF80_0000;
  localparam logic [31:0] QN = 32'h7FC0_0000, QN2 = 32'hFFC0_0123;
  localparam logic [31:0] SN = 32'h7F80_0001, SN2 = 32'hFF80_0005;
  localparam logic [31:0] SUB1 = 32'h0000_0001, SUB2 = 32'h0040_0000;
  localparam logic [31:0] NSUB = 32'h8000_0003;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] a = '0, b = '0;
  logic        out_valid, inv;
  logic [31:0] res;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [32:0] exp_q [$];
  string       tag_q [$];

  fmm_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .op_i(op),
    .a_i(a), .b_i(b), .out_valid_o(out_valid), .result_o(res), .invalid_o(inv)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic is_nan(input logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction

  // model from the requirements: signed ordering key, -0 placed below +0
  function automatic logic [32:0] model(input logic [31:0] x, input logic [31:0] y,
                                        input logic [2:0] o);
    logic xs, ys;
    longint kx, ky;
    int c;
    xs = is_nan(x) && !x[22];
    ys = is_nan(y) && !y[22];
    if (is_nan(x) || is_nan(y)) begin
      if (o[1] && !xs && !ys && (is_nan(x) != is_nan(y)))
        return {1'b0, is_nan(x) ? y : x};
      return {xs | ys, 32'h7FC0_0000};
    end
    if (o[2] && x[30:0] != y[30:0]) c = (x[30:0] > y[30:0]) ? 1 : -1;
    else begin
      kx = x[31] ? -longint'(x[30:0]) - 1 : longint'(x[30:0]);
      ky = y[31] ? -longint'(y[30:0]) - 1 : longint'(y[30:0]);
      c = (kx > ky) ? 1 : ((kx < ky) ? -1 : 0);
    end
    if (o[0]) c = -c;
    return {1'b0, (c < 0) ? y : x};
  endfunction

  task automatic drive(input logic [31:0] x, input logic [31:0] y,
                       input logic [2:0] o, input string tag);
    @(negedge clk);
    in_valid = 1'b1; a = x; b = y; op = o;
    exp_q.push_back(model(x, y, o));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor: each pop compares one result
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      logic [32:0] e;
      string t;
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R2: unexpected out_valid, actual res=%h expected none", res);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({inv, res} !== e) begin
          fails++;
          $display("FAIL %s: actual inv=%b res=%h expected inv=%b res=%h",
                   t, inv, res, e[32], e[31:0]);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual cycles=%0d expected done", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R2: reset out_valid actual=%b expected 0", out_valid);
    end
    rst_n = 1'b1;
    idle(1);

    // R1 code map on one pair
    drive(P1, N2, 3'b000, "R1 max");
    drive(P1, N2, 3'b001, "R1 min");
    drive(P1, N2, 3'b110, "R1 maxNumMag");
    drive(P1, N2, 3'b111, "R1 minNumMag");
    drive(P1, N2, 3'b010, "R1 maxNum");
    drive(P1, N2, 3'b011, "R1 minNum");
    // R7 signs and zeros
    drive(PZ, NZ, 3'b000, "R7 max +0,-0");
    drive(NZ, PZ, 3'b001, "R7 min -0,+0");
    drive(PZ, NZ, 3'b001, "R7 min +0,-0");
    drive(N1, N2, 3'b000, "R7 max negs");
    drive(N1, N2, 3'b001, "R7 min negs");
    // R6 magnitude ranking
    drive(P15, P1, 3'b000, "R6 fraction");
    drive(P2, P15, 3'b001, "R6 exponent");
    drive(PI, P2, 3'b001, "R6 inf");
    drive(NI, N2, 3'b000, "R6 -inf");
    drive(SUB1, SUB2, 3'b000, "R6 subnormals");
    drive(SUB2, PZ, 3'b001, "R6 sub vs zero");
    drive(NSUB, NZ, 3'b000, "R6 neg sub");
    // R8 magnitude mode
    drive(N2, P1, 3'b110, "R8 neg larger mag");
    drive(N2, P1, 3'b111, "R8 min mag");
    drive(P1, N1, 3'b110, "R8 tie sign max");
    drive(N1, P1, 3'b111, "R8 tie sign min");
    drive(NI, P2, 3'b110, "R8 -inf mag");
    // R9 tie
    drive(P1, P1, 3'b001, "R9 equal");
    drive(NZ, NZ, 3'b110, "R9 equal -0");
    // R3 number preference
    drive(QN, P2, 3'b010, "R3 qnan a");
    drive(N1, QN2, 3'b011, "R3 qnan b");
    drive(QN, NZ, 3'b111, "R3 mag qnan");
    // R4 / R5 NaN path
    drive(QN, P2, 3'b000, "R4 plain qnan");
    drive(QN, QN2, 3'b010, "R4 two qnans");
    drive(SN, P1, 3'b010, "R5 snan num");
    drive(P1, SN2, 3'b001, "R5 snan b");
    drive(SN, QN, 3'b111, "R5 snan+qnan");
    // R10 code 100
    drive(N2, P1, 3'b100, "R10 mag max");
    drive(QN, P1, 3'b100, "R10 nan");
    drive(NZ, PZ, 3'b100, "R10 zeros");
    idle(2);
    // R2 gap: idle cycle must not raise out_valid
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R2: idle out_valid actual=%b expected 0", out_valid);
    end
    // R6 sweep, pseudo-random, with gaps
    s = 32'h1234_5678;
    for (int i = 0; i < 300; i++) begin
      logic [31:0] x, y;
      s = s ^ (s << 13); s = s ^ (s >> 17); x = s ^ (s << 5); s = x;
      s = s ^ (s << 13); s = s ^ (s >> 17); y = s ^ (s << 5); s = y;
      drive(x, (i % 7 == 0) ? {~x[31], x[30:0]} : y, 3'(i), "R6 sweep");
      if (i % 5 == 0) idle(1);
    end
    idle(3);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R2: pending actual=%0d expected 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule